// File: doc/BRIEF.md
# Adaptive-Rate Digital LDO Controller

This block is the control logic of a digital low-dropout regulator. A bank of identical, parallel power switches sits between the input rail and the regulated load. The block decides how many of those switches are on. On each sampling tick it reads a single comparator decision that says whether the regulated output sits below or above the reference. It then moves the number of enabled switches up or down and drives them as a thermometer code. The comparator, the references, the threshold calibration and the switches themselves live outside this block. All of their results arrive here as already-synchronized digital inputs.

Sampling is gated by an internal clock-enable divider with two programmable ratios. In steady state the loop samples slowly, which lowers switching activity and steadies the output. Two extra flags report a large droop or a large overshoot. Either flag moves the loop to the fast ratio at once. While it runs fast, a droop steps the switch count up by a programmable larger increment and an overshoot steps it down by that increment. The loop returns to the slow ratio only after a programmable hold-off with both flags clear.

A bypass request turns every switch on and ties the load to the input rail. The loop is active only while software holds its enable high.

Top module: `ldo_rate_ctrl`

## Requirements
- R1: After reset, `sw_en_o` is all zeros and `fast_o` is 0.
- R2: In the slow rate the comparator is sampled once every `slow_div_i` enabled cycles. A sample with `below_i`=1 raises the switch count by one, and a sample with `below_i`=0 lowers it by one.
- R3: The switch count never goes below 0 or above `N_SW`. A step that would cross either limit stops at that limit.
- R4: `sw_en_o` is a thermometer code of the count: bit i is 1 exactly when i < count, so bit 0 is the first switch turned on. In any slow-rate step at most one bit changes.
- R5: When the loop is enabled, not bypassed and `droop_i` or `over_i` is high, `fast_o` is 1 from the next cycle on. In that state samples come every `fast_div_i` cycles.
- R6: A fast-rate sample with `droop_i`=1 adds `big_step_i`. Otherwise a fast-rate sample with `over_i`=1 subtracts `big_step_i`, so droop wins when both are high. A fast-rate sample with neither flag follows `below_i` by ±1. All of these steps are clamped as in R3.
- R7: In the fast rate, `fast_o` falls at the edge that ends the (`holdoff_i`×`slow_div_i`+1)-th consecutive enabled cycle with both flags low. Any flag restarts that count.
- R8: A divider ratio of 0 acts as 1. The divider phase restarts on every rate change and on every exit from disable or bypass, so the first sample comes in the d-th cycle of the new phase, where d is the effective ratio.
- R9: While `bypass_i` is 1, `sw_en_o` is all ones in the same cycle. The rate is forced slow, and the count is loaded with `N_SW`, so regulation resumes from all switches on.
- R10: While `en_i` is 0 and `bypass_i` is 0, the count is cleared to 0 and the rate is forced slow. The comparator and the excursion flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Software enable of the regulating loop |
| bypass_i | input | 1 | Request to turn every switch on |
| below_i | input | 1 | Main comparator: 1 = output below reference |
| droop_i | input | 1 | Large-droop threshold flag |
| over_i | input | 1 | Large-overshoot threshold flag |
| slow_div_i | input | DW (4) | Cycles between samples in the slow rate |
| fast_div_i | input | DW (4) | Cycles between samples in the fast rate |
| big_step_i | input | CW (5) | Switch-count increment used for fast-rate excursions |
| holdoff_i | input | HW (4) | Quiet slow intervals required before leaving the fast rate |
| sw_en_o | output | N_SW (16) | Thermometer-coded power-switch enables |
| fast_o | output | 1 | 1 while the loop samples at the fast rate |

## Verification
A steady below-reference pattern and then a steady above-reference pattern drive the count into both rails. This separates a correct slow-rate cadence and clamp from off-by-one sampling or wrap-around. Short droop and overshoot bursts, bursts with both flags high and flag chatter during the hold-off separate the big-step direction, the droop priority and the exact hold-off restart. A pseudo-random mix of comparator values, flags, bypass and disable runs under several divider and step settings. It exposes interactions between rate changes, divider phase restarts and the bypass and disable overrides, against a behavioural model compared on every clock.

// File: rtl/ldo_ctrl_pkg.sv
package ldo_ctrl_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/ldo_rate_div.sv
module ldo_rate_div #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          fast_i,
  input  logic          restart_i,
  input  logic [DW-1:0] slow_div_i,
  input  logic [DW-1:0] fast_div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q, div_sel, div_eff;

  always_comb begin
    div_sel = fast_i ? fast_div_i : slow_div_i;
    div_eff = (div_sel == '0) ? DW'(1) : div_sel;
    tick_o  = run_i && (cnt_q >= div_eff - DW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + DW'(1);
  end

  // R8
  restart_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || restart_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ldo_rate_fsm.sv
module ldo_rate_fsm
  import ldo_ctrl_pkg::*;
#(
  parameter int DW = 4,
  parameter int HW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          droop_i,
  input  logic          over_i,
  input  logic [DW-1:0] slow_div_i,
  input  logic [HW-1:0] holdoff_i,
  output rate_e         rate_o,
  output logic          restart_o
);
  rate_e         rate_q, rate_d;
  logic [DW-1:0] qc_q, qc_d, sdiv_eff;
  logic [HW-1:0] qi_q, qi_d;
  logic          flag;

  always_comb begin
    flag     = droop_i | over_i;
    sdiv_eff = (slow_div_i == '0) ? DW'(1) : slow_div_i;
    rate_d   = rate_q;
    qc_d     = qc_q;
    qi_d     = qi_q;
    if (!run_i) begin
      rate_d = RATE_SLOW;
      qc_d   = '0;
      qi_d   = '0;
    end else if (flag) begin
      rate_d = RATE_FAST;
      qc_d   = '0;
      qi_d   = '0;
    end else if (rate_q == RATE_FAST) begin
      // quiet time counted in slow intervals: qc = cycles, qi = intervals
      if (qi_q == holdoff_i) begin
        rate_d = RATE_SLOW;
        qc_d   = '0;
        qi_d   = '0;
      end else if (qc_q >= sdiv_eff - DW'(1)) begin
        qc_d = '0;
        qi_d = qi_q + HW'(1);
      end else begin
        qc_d = qc_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= RATE_SLOW;
      qc_q   <= '0;
      qi_q   <= '0;
    end else begin
      rate_q <= rate_d;
      qc_q   <= qc_d;
      qi_q   <= qi_d;
    end
  end

  assign rate_o    = rate_q;
  assign restart_o = (rate_d != rate_q);

  // R5
  flag_to_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (droop_i || over_i)) |=> (rate_q == RATE_FAST));
  // R10
  idle_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (rate_q == RATE_SLOW));
endmodule

// File: rtl/ldo_sw_count.sv
module ldo_sw_count #(
  parameter int N_SW = 16,
  parameter int CW   = $clog2(N_SW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            bypass_i,
  input  logic            tick_i,
  input  logic            fast_i,
  input  logic            below_i,
  input  logic            droop_i,
  input  logic            over_i,
  input  logic [CW-1:0]   big_step_i,
  output logic [N_SW-1:0] therm_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(N_SW);

  logic [CW-1:0] cnt_q, amt, cnt_nxt;
  logic [CW:0]   sum;
  logic          go_up;

  always_comb begin
    if (fast_i && droop_i) begin
      go_up = 1'b1;
      amt   = big_step_i;
    end else if (fast_i && over_i) begin
      go_up = 1'b0;
      amt   = big_step_i;
    end else begin
      go_up = below_i;
      amt   = CW'(1);
    end
    sum = {1'b0, cnt_q} + {1'b0, amt};
    if (go_up) cnt_nxt = (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[CW-1:0];
    else       cnt_nxt = (amt > cnt_q) ? '0 : cnt_q - amt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (bypass_i) cnt_q <= CNT_MAX;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_nxt;
  end

  for (genvar i = 0; i < N_SW; i++) begin : g_therm
    assign therm_o[i] = (cnt_q > CW'(i));
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  // R4
  therm_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o + N_SW'(1)) & therm_o) == '0);
  // R4
  slow_one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fast_i) |=> ($countones(therm_o ^ $past(therm_o)) <= 1));
endmodule

// File: rtl/ldo_rate_ctrl.sv
module ldo_rate_ctrl
  import ldo_ctrl_pkg::*;
#(
  parameter int N_SW = 16,
  parameter int DW   = 4,
  parameter int HW   = 4,
  parameter int CW   = $clog2(N_SW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            bypass_i,
  input  logic            below_i,
  input  logic            droop_i,
  input  logic            over_i,
  input  logic [DW-1:0]   slow_div_i,
  input  logic [DW-1:0]   fast_div_i,
  input  logic [CW-1:0]   big_step_i,
  input  logic [HW-1:0]   holdoff_i,
  output logic [N_SW-1:0] sw_en_o,
  output logic            fast_o
);
  rate_e           rate;
  logic            run, restart, tick, fast;
  logic [N_SW-1:0] therm;

  assign run  = en_i & ~bypass_i;
  assign fast = (rate == RATE_FAST);

  ldo_rate_fsm #(.DW(DW), .HW(HW)) i_fsm (
    .clk_i, .rst_ni, .run_i(run), .droop_i, .over_i,
    .slow_div_i, .holdoff_i, .rate_o(rate), .restart_o(restart)
  );

  ldo_rate_div #(.DW(DW)) i_div (
    .clk_i, .rst_ni, .run_i(run), .fast_i(fast), .restart_i(restart),
    .slow_div_i, .fast_div_i, .tick_o(tick)
  );

  ldo_sw_count #(.N_SW(N_SW), .CW(CW)) i_cnt (
    .clk_i, .rst_ni, .run_i(run), .bypass_i, .tick_i(tick), .fast_i(fast),
    .below_i, .droop_i, .over_i, .big_step_i, .therm_o(therm)
  );

  assign sw_en_o = bypass_i ? '1 : therm;
  assign fast_o  = fast;

  // R9
  bypass_all_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (&sw_en_o));
  // R9
  bypass_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> !fast_o);
endmodule

// File: tb/test_ldo_rate_ctrl.sv
module test_ldo_rate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int DW = 4;
  localparam int HW = 4;
  localparam int CW = $clog2(N + 1);

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          en_i = 0, bypass_i = 0, below_i = 0, droop_i = 0, over_i = 0;
  logic [DW-1:0] slow_div_i = 8, fast_div_i = 1;
  logic [CW-1:0] big_step_i = 4;
  logic [HW-1:0] holdoff_i = 2;
  logic [N-1:0]  sw_en_o;
  logic          fast_o;

  int    n_run = 0, n_fail = 0;
  bit    chk_on = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_div = 0, m_fast = 0, m_q = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ldo_rate_ctrl i_ldo_rate_ctrl (
    .clk_i, .rst_ni, .en_i, .bypass_i, .below_i, .droop_i, .over_i,
    .slow_div_i, .fast_div_i, .big_step_i, .holdoff_i, .sw_en_o, .fast_o
  );

  function automatic logic [N-1:0] therm(int c);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) if (i < c) v[i] = 1'b1;
    return v;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_div = 0; m_fast = 0; m_q = 0;
    end else if (!en_i || bypass_i) begin
      m_cnt  = bypass_i ? N : 0;
      m_div  = 0; m_fast = 0; m_q = 0;
    end else begin
      int d, sd, c, nf;
      bit tk, fl;
      d  = m_fast ? int'(fast_div_i) : int'(slow_div_i);
      if (d < 1) d = 1;
      sd = (slow_div_i == 0) ? 1 : int'(slow_div_i);
      tk = (m_div >= d - 1);
      fl = droop_i || over_i;
      c  = m_cnt;
      if (tk) begin
        if (m_fast && droop_i)     c = m_cnt + int'(big_step_i);
        else if (m_fast && over_i) c = m_cnt - int'(big_step_i);
        else                       c = below_i ? m_cnt + 1 : m_cnt - 1;
        if (c > N) c = N;
        if (c < 0) c = 0;
      end
      if (fl) begin
        nf = 1; m_q = 0;
      end else if (!m_fast) begin
        nf = 0; m_q = 0;
      end else if (m_q >= int'(holdoff_i) * sd) begin
        nf = 0; m_q = 0;
      end else begin
        nf = 1; m_q = m_q + 1;
      end
      if (nf != m_fast) m_div = 0;
      else              m_div = tk ? 0 : m_div + 1;
      m_fast = nf;
      m_cnt  = c;
    end
  end

  task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk_i) begin
    if (chk_on && rst_ni) begin
      check(cur_req, "sw_en_o", sw_en_o, bypass_i ? '1 : therm(m_cnt));
      check(cur_req, "fast_o", N'(fast_o), N'(m_fast));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1", "reset sw_en_o", sw_en_o, '0);
    check("R1", "reset fast_o", N'(fast_o), '0);
    rst_ni = 1'b1;
    chk_on = 1;
    cyc(2);

    // R2 slow cadence upward, R3 upper clamp
    cur_req = "R2"; en_i = 1; below_i = 1;
    cyc(17);
    check("R2", "two slow samples up", sw_en_o, therm(2));
    cur_req = "R3"; cyc(150);
    check("R3", "clamped at full", sw_en_o, '1);
    // R4 thermometer downward, R3 lower clamp
    cur_req = "R4"; below_i = 0; cyc(8);
    check("R4", "one switch off", sw_en_o, therm(N - 1));
    cur_req = "R3"; cyc(150);
    check("R3", "clamped at zero", sw_en_o, '0);

    // R5/R6 droop burst
    cur_req = "R6"; below_i = 1; cyc(24);
    droop_i = 1; cyc(1);
    check("R5", "fast after droop", N'(fast_o), N'(1));
    cyc(2); droop_i = 0;
    // R7 hold-off with chatter
    cur_req = "R7"; cyc(10);
    over_i = 1; cyc(2); over_i = 0;
    cyc(int'(holdoff_i) * int'(slow_div_i));
    check("R7", "still fast at hold-off edge", N'(fast_o), N'(1));
    cyc(1);
    check("R7", "slow after hold-off", N'(fast_o), N'(0));
    // R6 both flags: droop wins
    cur_req = "R6"; droop_i = 1; over_i = 1; cyc(3);
    droop_i = 0; cyc(3); over_i = 0; cyc(40);

    // R9 bypass
    cur_req = "R9"; bypass_i = 1; #1;
    check("R9", "bypass immediate", sw_en_o, '1);
    droop_i = 1; cyc(5); droop_i = 0;
    check("R9", "bypass slow", N'(fast_o), N'(0));
    bypass_i = 0; below_i = 0; cyc(8);
    check("R9", "resume from full", sw_en_o, therm(N - 1));

    // R10 disable ignores flags and comparator
    cur_req = "R10"; en_i = 0; droop_i = 1; below_i = 1; cyc(6);
    check("R10", "disabled count", sw_en_o, '0);
    check("R10", "disabled rate", N'(fast_o), N'(0));
    droop_i = 0;

    // R8 zero ratio acts as one
    cur_req = "R8"; slow_div_i = 0; fast_div_i = 3; en_i = 1; cyc(5);
    check("R8", "ratio 0 samples every cycle", sw_en_o, therm(5));
    cyc(20);

    // randomized mix under several settings
    for (int s = 0; s < 4; s++) begin
      en_i = 0; cyc(2);
      slow_div_i = DW'($urandom_range(0, 9));
      fast_div_i = DW'($urandom_range(0, 3));
      big_step_i = CW'($urandom_range(1, 7));
      holdoff_i  = HW'($urandom_range(0, 3));
      en_i = 1;
      cur_req = (s % 2 == 0) ? "R6" : "R7";
      for (int k = 0; k < 600; k++) begin
        below_i  = ($urandom_range(0, 99) < 55);
        droop_i  = ($urandom_range(0, 99) < 4);
        over_i   = ($urandom_range(0, 99) < 4);
        bypass_i = ($urandom_range(0, 199) < 2);
        en_i     = ($urandom_range(0, 199) >= 2);
        cyc(1);
      end
    end
    bypass_i = 0; droop_i = 0; over_i = 0; en_i = 1;
    cyc(3);
    chk_on = 0;
    summary();
  end
endmodule